// File: doc/BRIEF.md
# Single to Half Precision Narrowing Converter

This block narrows an IEEE-754 binary32 bit pattern to a binary16 bit pattern in one registered stage. A 32-bit word arrives with a valid strobe. One clock later the 16-bit result appears with its own valid. A new word may be presented on every cycle. The block raises no exception flags. Overflow, underflow and invalid results are encoded only in the output pattern.

Each input word is first sorted into one of five value classes: signed zero, half subnormal, half normal, infinity (which includes overflow), and NaN. The classes are decided by the biased input exponent `e` (bits 30:23) and by whether the fraction (bits 22:0) is nonzero. The subnormal and normal classes share one align-and-round path. In that path the rounded significand is added to the exponent field rather than concatenated with it. As a result, a rounding carry moves the largest subnormal to the smallest normal, and moves the top normal binade to infinity.

The parameter `TIES_EVEN` selects the tie rule. A value of 1 rounds half to even. A value of 0 rounds half away from zero.

Top module: `fp32_to_fp16_narrow`

## Requirements
- R1: A synchronous active-high reset clears `out_bits` and `out_valid` to zero at the next clock edge.
- R2: `out_valid` equals `in_valid` of the previous cycle, and a word presented in every consecutive cycle yields a result in every following cycle.
- R3: In a cycle with `in_valid` low, `out_bits` keeps its previous value at the next edge.
- R4: Output bit 15 equals input bit 31 for every input class.
- R5: If `e` = 255 and the fraction is nonzero, the magnitude (bits 14:0) is 0x7C00 plus fraction bits 22:13. If those ten bits are all zero, the magnitude is 0x7C01.
- R6: If `e` = 255 with a zero fraction, or if 143 <= `e` <= 254, the magnitude is 0x7C00.
- R7: If `e` < 102, the magnitude is 0. This covers input zeros and input subnormals.
- R8: If 102 <= `e` <= 112, the value {1, fraction} is shifted right by (113 - `e`) and then rounded at bit 13. The magnitude is the rounded value shifted right by 13. A carry into bit 10 gives 0x0400.
- R9: If 113 <= `e` <= 142, the magnitude is ((`e` - 112) << 10) plus the rounded fraction shifted right by 13. A carry increments the exponent, so from `e` = 142 it can reach 0x7C00.
- R10: Rounding adds 0x1000 to the aligned significand. With `TIES_EVEN` = 1, the addition is skipped when the low 14 bits of that significand equal exactly 0x1000. With `TIES_EVEN` = 0, the addition is always made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word strobe |
| in_bits | input | 32 | binary32 bit pattern |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_bits | output | 16 | binary16 bit pattern |

## Verification
Directed words cover each class boundary: exponents 101/102, 112/113 and 142/143, NaNs whose top ten fraction bits are zero, and signed zeros and infinities. Exact ties with an odd and with an even kept bit are applied at the subnormal edge, at 1.0 and at the top of the normal range. Two instances with opposite tie rules receive these words, so a mismatch between them shows which rounding rule is in effect. Random words are weighted toward the subnormal, overflow and tie regions, and a fraction with exactly the tie bit set tells a sticky bit that is wrongly kept apart from one that is correctly dropped. Idle cycles and a reset in mid-stream show whether the result holds or clears.

// File: rtl/fp_narrow_pkg.sv
package fp_narrow_pkg;

    localparam int SRC_EXP_W  = 8;
    localparam int SRC_FRAC_W = 23;
    localparam int SRC_W      = 1 + SRC_EXP_W + SRC_FRAC_W;
    localparam int DST_EXP_W  = 5;
    localparam int DST_FRAC_W = 10;
    localparam int DST_W      = 1 + DST_EXP_W + DST_FRAC_W;
    localparam int MAG_W      = DST_W - 1;

    localparam int DROP_W     = SRC_FRAC_W - DST_FRAC_W;
    localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;
    localparam int DST_BIAS   = (1 << (DST_EXP_W - 1)) - 1;
    localparam int BIAS_GAP   = SRC_BIAS - DST_BIAS;
    localparam int SRC_EMAX   = (1 << SRC_EXP_W) - 1;
    localparam int DST_EMAX   = (1 << DST_EXP_W) - 1;
    localparam int OVF_EXP    = BIAS_GAP + DST_EMAX;
    localparam int ZERO_BELOW = BIAS_GAP - DST_FRAC_W;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } val_class_e;

endpackage

// File: rtl/fn_classify.sv
module fn_classify
    import fp_narrow_pkg::*;
(
    input  logic [SRC_EXP_W-1:0] exp_i,
    input  logic                 frac_nz_i,
    output val_class_e           cls_o
);

    always_comb begin
        if (exp_i == SRC_EXP_W'(SRC_EMAX)) begin
            cls_o = frac_nz_i ? CLS_NAN : CLS_INF;
        end else if (exp_i >= SRC_EXP_W'(OVF_EXP)) begin
            cls_o = CLS_INF;
        end else if (exp_i < SRC_EXP_W'(ZERO_BELOW)) begin
            cls_o = CLS_ZERO;
        end else if (exp_i <= SRC_EXP_W'(BIAS_GAP)) begin
            cls_o = CLS_SUB;
        end else begin
            cls_o = CLS_NORM;
        end
    end

endmodule

// File: rtl/fn_align_round.sv
module fn_align_round
    import fp_narrow_pkg::*;
#(
    parameter bit TIES_EVEN = 1'b1
) (
    input  val_class_e            cls_i,
    input  logic [SRC_EXP_W-1:0]  exp_i,
    input  logic [SRC_FRAC_W-1:0] frac_i,
    output logic [MAG_W-1:0]      mag_o
);

    localparam int ALIGN_W = SRC_FRAC_W + 1;
    localparam logic [DROP_W:0]    TIE_PAT  = (DROP_W+1)'(1) << (DROP_W - 1);
    localparam logic [ALIGN_W-1:0] HALF_ULP = ALIGN_W'(1) << (DROP_W - 1);

    logic [ALIGN_W-1:0]   aligned;
    logic [SRC_EXP_W-1:0] shamt;
    logic [DST_EXP_W-1:0] base_exp;
    logic                 bump;
    logic [DST_FRAC_W:0]  hsig;

    // subnormal path restores the hidden bit and shifts it down
    always_comb begin
        shamt = SRC_EXP_W'(BIAS_GAP + 1) - exp_i;
        if (cls_i == CLS_SUB) begin
            aligned  = {1'b1, frac_i} >> shamt;
            base_exp = '0;
        end else begin
            aligned  = {1'b0, frac_i};
            base_exp = DST_EXP_W'(exp_i - SRC_EXP_W'(BIAS_GAP));
        end
    end

    generate
        if (TIES_EVEN) begin : g_tie_even
            assign bump = (aligned[DROP_W:0] != TIE_PAT);
        end else begin : g_tie_away
            assign bump = 1'b1;
        end
    endgenerate

    assign hsig  = (DST_FRAC_W+1)'((aligned + (bump ? HALF_ULP : '0)) >> DROP_W);
    // add, not concatenate: a carry out of the fraction bumps the exponent
    assign mag_o = {base_exp, {DST_FRAC_W{1'b0}}} + MAG_W'(hsig);

endmodule

// File: rtl/fp32_to_fp16_narrow.sv
module fp32_to_fp16_narrow
    import fp_narrow_pkg::*;
#(
    parameter bit TIES_EVEN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SRC_W-1:0]  in_bits,
    output logic              out_valid,
    output logic [DST_W-1:0]  out_bits
);

    localparam logic [MAG_W-1:0] INF_MAG = {{DST_EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};

    logic                  sign;
    logic [SRC_EXP_W-1:0]  exp_f;
    logic [SRC_FRAC_W-1:0] frac_f;
    logic [DST_FRAC_W-1:0] nan_pay;
    val_class_e            cls;
    logic [MAG_W-1:0]      rnd_mag;
    logic [MAG_W-1:0]      nan_mag;
    logic [MAG_W-1:0]      sel_mag;

    assign sign    = in_bits[SRC_W-1];
    assign exp_f   = in_bits[SRC_W-2 -: SRC_EXP_W];
    assign frac_f  = in_bits[SRC_FRAC_W-1:0];
    assign nan_pay = frac_f[SRC_FRAC_W-1 -: DST_FRAC_W];

    fn_classify u_cls (
        .exp_i     (exp_f),
        .frac_nz_i (|frac_f),
        .cls_o     (cls)
    );

    fn_align_round #(.TIES_EVEN(TIES_EVEN)) u_rnd (
        .cls_i  (cls),
        .exp_i  (exp_f),
        .frac_i (frac_f),
        .mag_o  (rnd_mag)
    );

    // a payload that truncates to zero must still read as NaN
    assign nan_mag = (nan_pay == '0) ? (INF_MAG | MAG_W'(1))
                                     : (INF_MAG | MAG_W'(nan_pay));

    always_comb begin
        unique case (cls)
            CLS_ZERO: sel_mag = '0;
            CLS_INF:  sel_mag = INF_MAG;
            CLS_NAN:  sel_mag = nan_mag;
            default:  sel_mag = rnd_mag;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bits  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bits <= {sign, sel_mag};
            end
        end
    end

endmodule

// File: rtl/fn_narrow_chk.sv
module fn_narrow_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_bits,
    input logic        out_valid,
    input logic [15:0] out_bits
);

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_bits));

    p_sign_copy_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_bits[15] == $past(in_bits[31]));

    p_nan_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bits[30:23] == 8'hFF && in_bits[22:0] != 23'd0)
        |=> (out_bits[14:10] == 5'h1F && out_bits[9:0] != 10'd0));

    p_inf_out_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bits[30:23] >= 8'd143
         && !(in_bits[30:23] == 8'hFF && in_bits[22:0] != 23'd0))
        |=> out_bits[14:0] == 15'h7C00);

    p_flush_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bits[30:23] < 8'd102) |=> out_bits[14:0] == 15'd0);

    p_sub_range_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bits[30:23] >= 8'd102 && in_bits[30:23] <= 8'd112)
        |=> out_bits[14:0] <= 15'h0400);

    p_norm_range_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bits[30:23] >= 8'd113 && in_bits[30:23] <= 8'd142)
        |=> (out_bits[14:10] >= 5'd1 && out_bits[14:0] <= 15'h7C00));

endmodule

bind fp32_to_fp16_narrow fn_narrow_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bits   (in_bits),
    .out_valid (out_valid),
    .out_bits  (out_bits)
);

// File: tb/sim_fp32_to_fp16_narrow.sv
`timescale 1ns/1ps
module sim_fp32_to_fp16_narrow;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = 32'd0;
    logic        ov0, ov1;
    logic [15:0] ob0, ob1;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    fp32_to_fp16_narrow #(.TIES_EVEN(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
        .out_valid(ov0), .out_bits(ob0));

    fp32_to_fp16_narrow #(.TIES_EVEN(1'b0)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
        .out_valid(ov1), .out_bits(ob1));

    // reference: round up when the dropped part exceeds half,
    // or equals half and the rule says so
    function automatic logic [15:0] ref_half(input logic [31:0] f, input bit even);
        int e;
        int fr;
        int m;
        int lo;
        int up;
        int mag;
        e  = int'(f[30:23]);
        fr = int'(f[22:0]);
        if (e == 255) begin
            if (fr != 0) mag = ((fr >> 13) == 0) ? 'h7C01 : ('h7C00 | (fr >> 13));
            else         mag = 'h7C00;
        end else if (e >= 143) begin
            mag = 'h7C00;
        end else if (e < 102) begin
            mag = 0;
        end else begin
            if (e <= 112) m = ('h800000 | fr) >> (113 - e);
            else          m = fr;
            lo = m & 'h1FFF;
            up = m >> 13;
            if (lo > 'h1000 || (lo == 'h1000 && (!even || (up & 1) == 1))) up = up + 1;
            mag = ((e > 112) ? ((e - 112) << 10) : 0) + up;
        end
        return {f[31], mag[14:0]};
    endfunction

    function automatic string req_of(input logic [31:0] f);
        if (f[30:23] == 8'hFF && f[22:0] != 0) return "R5";
        if (f[30:23] >= 8'd143)               return "R6";
        if (f[30:23] < 8'd102)                return "R7";
        if (f[30:23] <= 8'd112)               return "R8";
        return "R9";
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at a falling edge, read the registered result one cycle later
    task automatic send(input logic [31:0] v);
        logic [15:0] e0;
        logic [15:0] e1;
        in_valid = 1'b1;
        in_bits  = v;
        @(negedge clk);
        e0 = ref_half(v, 1'b1);
        e1 = ref_half(v, 1'b0);
        check(ob0 == e0, req_of(v), {16'd0, ob0}, {16'd0, e0});
        check(ob1 == e1, "R10", {16'd0, ob1}, {16'd0, e1});
        check(ob0[15] == v[31], "R4", {31'd0, ob0[15]}, {31'd0, v[31]});
        check(ov0 && ov1, "R2", {30'd0, ov0, ov1}, 32'd3);
    endtask

    task automatic known(input logic [31:0] v, input logic [15:0] e_even,
                         input logic [15:0] e_away, input string req);
        in_valid = 1'b1;
        in_bits  = v;
        @(negedge clk);
        check(ob0 == e_even, req, {16'd0, ob0}, {16'd0, e_even});
        check(ob1 == e_away, "R10", {16'd0, ob1}, {16'd0, e_away});
    endtask

    function automatic logic [31:0] rand_word();
        logic [31:0] w;
        int sel;
        w   = $urandom;
        sel = $urandom_range(0, 9);
        case (sel)
            0: w[30:23] = 8'($urandom_range(100, 114));
            1: w[30:23] = 8'($urandom_range(140, 145));
            2: w[30:23] = 8'hFF;
            3: w[12:0]  = 13'h1000;
            4: begin w[30:23] = 8'($urandom_range(102, 142)); w[12:0] = 13'h1000; end
            5: w[30:23] = 8'($urandom_range(0, 101));
            default: ;
        endcase
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(ob0 == 16'd0 && !ov0, "R1", {15'd0, ov0, ob0}, 32'd0);
        rst = 1'b0;

        // hand-computed anchors
        known(32'h3F800000, 16'h3C00, 16'h3C00, "R9");
        known(32'h3F801000, 16'h3C00, 16'h3C01, "R9");
        known(32'h3F803000, 16'h3C02, 16'h3C02, "R9");
        known(32'h33000000, 16'h0000, 16'h0001, "R8");
        known(32'h477FF000, 16'h7C00, 16'h7C00, "R9");
        known(32'h477FE000, 16'h7BFF, 16'h7BFF, "R9");
        known(32'h7F800001, 16'h7C01, 16'h7C01, "R5");
        known(32'hFF800000, 16'hFC00, 16'hFC00, "R6");
        known(32'h47800000, 16'h7C00, 16'h7C00, "R6");
        known(32'h80000000, 16'h8000, 16'h8000, "R7");
        known(32'h387FF000, 16'h0400, 16'h0400, "R8");

        // class edges and ties
        send(32'h00000000); send(32'h807FFFFF); send(32'h32FFFFFF);
        send(32'h33000001); send(32'h33800000); send(32'h38000000);
        send(32'h387FE000); send(32'h387FEFFF); send(32'h38800000);
        send(32'h38801000); send(32'h38803000); send(32'h477FEFFF);
        send(32'hC77FF000); send(32'h7FC00000); send(32'hFF802000);
        send(32'h7F7FFFFF); send(32'hB8FFF000); send(32'h33C00000);

        // idle: result held, valid dropped
        begin
            logic [15:0] held;
            held = ob0;
            in_valid = 1'b0;
            in_bits  = 32'h3F800000;
            @(negedge clk);
            check(ob0 == held, "R3", {16'd0, ob0}, {16'd0, held});
            check(!ov0, "R2", {31'd0, ov0}, 32'd0);
        end

        for (int i = 0; i < 4000; i++) begin
            send(rand_word());
            if (i % 500 == 250) begin
                logic [15:0] held;
                held = ob0;
                in_valid = 1'b0;
                in_bits  = $urandom;
                @(negedge clk);
                check(ob0 == held && !ov0, "R3", {15'd0, ov0, ob0}, {16'd0, held});
            end
        end

        // reset in mid-stream
        in_valid = 1'b1;
        in_bits  = 32'hC0490FDB;
        rst      = 1'b1;
        @(negedge clk);
        check(ob0 == 16'd0 && !ov0, "R1", {15'd0, ov0, ob0}, 32'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule